// File: doc/BRIEF.md
# Load-Store Alignment and Extension Unit

This unit sits between the execute stage of a 32-bit core and a byte-addressed, 32-bit-wide data memory. The core offers one memory instruction at a time: the raw instruction word, the base register value and, for stores, the source register value. The unit decodes the opcode, forms the effective address, raises a request on the memory port with per-byte write enables and lane-aligned write data, and waits for the memory to acknowledge. For loads it takes the addressed byte, halfword or word out of the returned word and widens it to 32 bits with zero or sign fill. It then presents the result for one cycle.

The memory is big-endian: address offset 0 within a word is the most significant byte. Halfword and word accesses must be naturally aligned. A misaligned access is refused. The unit raises a flag for one cycle and the memory is never touched.

The core-facing side is a valid/ready handshake. An offer is taken on a clock edge where `op_valid` and `op_ready` are both high. `op_ready` falls on that edge and stays low until the memory acknowledges. An offer held during that time is simply not taken, and the core must keep it, or withdraw it, itself. The load result has no back-pressure: `ld_valid` is a single-cycle pulse and the core must take `ld_data` in that cycle.

Top module: `lsu_align`

## Requirements
- R1: For loads, the offset is instruction bits [15:0], sign-extended. The effective address `op_ra + offset` appears unchanged on `mem_addr` while the request is up.
- R2: For stores, the 16-bit offset is rebuilt as {instruction bits [25:21], instruction bits [10:0]}, then sign-extended and added to `op_ra`.
- R3: The opcode in bits [31:26] is decoded as follows. 0x21 is a word load and 0x22 is a signed word load. 0x23 is an unsigned byte load and 0x24 a signed byte load. 0x25 is an unsigned halfword load and 0x26 a signed halfword load. 0x35 is a word store, 0x36 a byte store and 0x37 a halfword store. Any other opcode is accepted but causes no request, no flag and no load pulse.
- R4: Enable bit `mem_be[3]` covers data bits [31:24], and so on down to `mem_be[0]` for bits [7:0]. A byte at offset k asserts only `mem_be[3-k]`. A halfword at offset 0 asserts 4'b1100 and at offset 2 asserts 4'b0011. A word asserts 4'b1111.
- R5: A store raises `mem_we`; a load does not. A byte store repeats `op_rb[7:0]` in all four lanes, a halfword store repeats `op_rb[15:0]` in both halves, and a word store drives `op_rb` as is.
- R6: An unsigned load returns the addressed byte or halfword in the low bits with the upper bits cleared. Byte lane k is `mem_rdata[31-8k -: 8]`, offset 0 selects the halfword `mem_rdata[31:16]` and offset 2 selects `mem_rdata[15:0]`. Both word loads return `mem_rdata` unchanged.
- R7: A signed byte or halfword load fills the upper bits with bit 7 or bit 15 of the loaded value.
- R8: A halfword access with address bit 0 set, or a word access with address bits [1:0] non-zero, raises `misalign` for exactly the cycle after acceptance and raises no memory request.
- R9: Out of reset, `op_ready` is high and no request is up. From acceptance until the acknowledge edge, `mem_req` stays high with stable address, enables, data and direction, and `op_ready` stays low. Offers made during that time are not taken.
- R10: One cycle after the acknowledge edge, a load pulses `ld_valid` for exactly one cycle with the extended value on `ld_data`. A store produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Core offers an instruction |
| op_ready | output | 1 | Unit idle; offer is taken on this edge |
| op_insn | input | 32 | Raw instruction word |
| op_ra | input | 32 | Base register value |
| op_rb | input | 32 | Store source register value |
| mem_req | output | 1 | Memory request, held until acknowledge |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte effective address |
| mem_be | output | 4 | Byte enables, bit 3 = bits [31:24] |
| mem_wdata | output | 32 | Lane-aligned write data |
| mem_ack | input | 1 | Memory completes the request |
| mem_rdata | input | 32 | Read word, valid with mem_ack |
| ld_valid | output | 1 | One-cycle load result strobe |
| ld_data | output | 32 | Extended load result |
| misalign | output | 1 | One-cycle misaligned-access flag |

## Verification
On every cycle the assertions check the request discipline. They confirm that a pending request holds its address, enables, data and direction until acknowledged, and that `op_ready` stays low meanwhile. They confirm that the enables form one, two or four lanes, that load pulses appear only after a read acknowledge and last one cycle, and that the misalignment flag never coincides with a request. The exact numbers can only be shown by the bench's sweep over every opcode, every address offset, positive and negative offsets, and sign-bit patterns. That covers the address arithmetic, the two store offset layouts, which lanes are enabled, the replicated write data and the extracted and extended load values.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  localparam logic [5:0] OPC_LD_WZ = 6'h21;
  localparam logic [5:0] OPC_LD_WS = 6'h22;
  localparam logic [5:0] OPC_LD_BZ = 6'h23;
  localparam logic [5:0] OPC_LD_BS = 6'h24;
  localparam logic [5:0] OPC_LD_HZ = 6'h25;
  localparam logic [5:0] OPC_LD_HS = 6'h26;
  localparam logic [5:0] OPC_ST_W  = 6'h35;
  localparam logic [5:0] OPC_ST_B  = 6'h36;
  localparam logic [5:0] OPC_ST_H  = 6'h37;

  typedef struct packed {
    logic        is_load;
    logic        is_store;
    acc_size_e   size;
    logic        sext;
    logic [15:0] offset;
  } mem_op_t;

endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
  import lsu_pkg::*;
(
  input  logic [31:0] insn,
  output mem_op_t     op
);
  logic [5:0]  opc;
  logic [15:0] ld_off;
  logic [15:0] st_off;
  logic        unused_fields;

  assign opc           = insn[31:26];
  assign ld_off        = insn[15:0];
  assign st_off        = {insn[25:21], insn[10:0]};
  assign unused_fields = ^insn[20:16];

  always_comb begin
    op          = '0;
    op.size     = SZ_WORD;
    op.offset   = ld_off;
    unique case (opc)
      OPC_LD_WZ: begin op.is_load = 1'b1; op.size = SZ_WORD; end
      OPC_LD_WS: begin op.is_load = 1'b1; op.size = SZ_WORD; op.sext = 1'b1; end
      OPC_LD_BZ: begin op.is_load = 1'b1; op.size = SZ_BYTE; end
      OPC_LD_BS: begin op.is_load = 1'b1; op.size = SZ_BYTE; op.sext = 1'b1; end
      OPC_LD_HZ: begin op.is_load = 1'b1; op.size = SZ_HALF; end
      OPC_LD_HS: begin op.is_load = 1'b1; op.size = SZ_HALF; op.sext = 1'b1; end
      OPC_ST_W:  begin op.is_store = 1'b1; op.size = SZ_WORD; op.offset = st_off; end
      OPC_ST_B:  begin op.is_store = 1'b1; op.size = SZ_BYTE; op.offset = st_off; end
      OPC_ST_H:  begin op.is_store = 1'b1; op.size = SZ_HALF; op.offset = st_off; end
      default:   op.is_load = 1'b0;
    endcase
  end
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
  import lsu_pkg::*;
#(
  parameter  int XLEN   = 32,
  localparam int NBYTES = XLEN / 8,
  localparam int LANE_W = $clog2(NBYTES)
) (
  input  acc_size_e         size,
  input  logic [LANE_W-1:0] lane,
  input  logic [XLEN-1:0]   src,
  output logic [NBYTES-1:0] be,
  output logic [XLEN-1:0]   wdata,
  output logic              misal
);
  // Big-endian: lane i occupies the i-th byte from the top, enable bit NBYTES-1-i
  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    assign be[NBYTES-1-i] =
      (size == SZ_BYTE) ? (lane == LANE_W'(i)) :
      (size == SZ_HALF) ? (lane[LANE_W-1:1] == (LANE_W-1)'(i / 2)) :
                          1'b1;
  end

  always_comb begin
    unique case (size)
      SZ_BYTE: wdata = {NBYTES{src[7:0]}};
      SZ_HALF: wdata = {(NBYTES/2){src[15:0]}};
      default: wdata = src;
    endcase
  end

  assign misal = ((size == SZ_HALF) && lane[0]) ||
                 ((size == SZ_WORD) && (lane != '0));
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_pkg::*;
#(
  parameter  int XLEN   = 32,
  localparam int NBYTES = XLEN / 8,
  localparam int LANE_W = $clog2(NBYTES)
) (
  input  acc_size_e         size,
  input  logic              sext,
  input  logic [LANE_W-1:0] lane,
  input  logic [XLEN-1:0]   rdata,
  output logic [XLEN-1:0]   value
);
  logic [7:0]        lane_byte [NBYTES];
  logic [LANE_W-1:0] hi_idx;
  logic [LANE_W-1:0] lo_idx;
  logic [7:0]        byte_v;
  logic [15:0]       half_v;

  for (genvar i = 0; i < NBYTES; i++) begin : g_split
    assign lane_byte[i] = rdata[XLEN-1-8*i -: 8];
  end

  assign hi_idx = {lane[LANE_W-1:1], 1'b0};
  assign lo_idx = {lane[LANE_W-1:1], 1'b1};
  assign byte_v = lane_byte[lane];
  assign half_v = {lane_byte[hi_idx], lane_byte[lo_idx]};

  always_comb begin
    unique case (size)
      SZ_BYTE: value = {{(XLEN-8){sext & byte_v[7]}}, byte_v};
      SZ_HALF: value = {{(XLEN-16){sext & half_v[15]}}, half_v};
      default: value = rdata;
    endcase
  end
endmodule

// File: rtl/lsu_align.sv
module lsu_align
  import lsu_pkg::*;
#(
  parameter  int XLEN   = 32,
  localparam int NBYTES = XLEN / 8,
  localparam int LANE_W = $clog2(NBYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [31:0]       op_insn,
  input  logic [XLEN-1:0]   op_ra,
  input  logic [XLEN-1:0]   op_rb,
  output logic              mem_req,
  output logic              mem_we,
  output logic [XLEN-1:0]   mem_addr,
  output logic [NBYTES-1:0] mem_be,
  output logic [XLEN-1:0]   mem_wdata,
  input  logic              mem_ack,
  input  logic [XLEN-1:0]   mem_rdata,
  output logic              ld_valid,
  output logic [XLEN-1:0]   ld_data,
  output logic              misalign
);
  mem_op_t           dec;
  logic [XLEN-1:0]   ea;
  logic [NBYTES-1:0] be_n;
  logic [XLEN-1:0]   wdata_n;
  logic              misal_n;
  logic              accept;

  acc_size_e         size_q;
  logic              sext_q;
  logic [LANE_W-1:0] lane_q;
  logic [XLEN-1:0]   ld_value;

  lsu_decode u_dec (
    .insn (op_insn),
    .op   (dec)
  );

  assign ea = op_ra + {{(XLEN-16){dec.offset[15]}}, dec.offset};

  lsu_store_lane #(.XLEN(XLEN)) u_st (
    .size  (dec.size),
    .lane  (ea[LANE_W-1:0]),
    .src   (op_rb),
    .be    (be_n),
    .wdata (wdata_n),
    .misal (misal_n)
  );

  lsu_load_extract #(.XLEN(XLEN)) u_ld (
    .size  (size_q),
    .sext  (sext_q),
    .lane  (lane_q),
    .rdata (mem_rdata),
    .value (ld_value)
  );

  assign op_ready = !mem_req;
  assign accept   = op_valid && op_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
      size_q    <= SZ_WORD;
      sext_q    <= 1'b0;
      lane_q    <= '0;
      ld_valid  <= 1'b0;
      ld_data   <= '0;
      misalign  <= 1'b0;
    end else begin
      ld_valid <= 1'b0;
      misalign <= 1'b0;
      if (accept && (dec.is_load || dec.is_store)) begin
        if (misal_n) begin
          misalign <= 1'b1;
        end else begin
          mem_req   <= 1'b1;
          mem_we    <= dec.is_store;
          mem_addr  <= ea;
          mem_be    <= be_n;
          mem_wdata <= dec.is_store ? wdata_n : '0;
          size_q    <= dec.size;
          sext_q    <= dec.sext;
          lane_q    <= ea[LANE_W-1:0];
        end
      end
      if (mem_req && mem_ack) begin
        mem_req <= 1'b0;
        if (!mem_we) begin
          ld_valid <= 1'b1;
          ld_data  <= ld_value;
        end
      end
    end
  end
endmodule

// File: rtl/lsu_align_chk.sv
module lsu_align_chk #(
  parameter  int XLEN   = 32,
  localparam int NBYTES = XLEN / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic              op_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic [XLEN-1:0]   mem_addr,
  input logic [NBYTES-1:0] mem_be,
  input logic [XLEN-1:0]   mem_wdata,
  input logic              mem_ack,
  input logic              ld_valid,
  input logic              misalign
);
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_be)
                            && $stable(mem_wdata) && $stable(mem_we));
  // R9
  ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !op_ready);
  // R9
  req_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(op_valid && op_ready));
  // R4
  be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ($countones(mem_be) == 1) || ($countones(mem_be) == 2)
                || ($countones(mem_be) == NBYTES));
  // R10
  ld_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $past(mem_req && mem_ack && !mem_we));
  // R10
  ld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> !ld_valid);
  // R8
  misal_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> !mem_req);
  // R8
  misal_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> $past(op_valid && op_ready));
endmodule

bind lsu_align lsu_align_chk #(.XLEN(XLEN)) chk_i (.*);

// File: tb/lsu_align_tb.sv
module lsu_align_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [31:0] op_insn = '0;
  logic [31:0] op_ra = '0;
  logic [31:0] op_rb = '0;
  logic        mem_req;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        ld_valid;
  logic [31:0] ld_data;
  logic        misalign;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  lsu_align dut_i (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [5:0] opc, input logic [15:0] off,
                        input logic [31:0] ra, input logic [31:0] rb,
                        input logic [31:0] rdata, input int delay, input bit probe);
    bit is_ld, is_st, sx;
    int sz;
    logic [31:0] ea, exp_wd, exp_ld;
    logic [3:0]  exp_be;
    logic [1:0]  ln;
    logic [7:0]  b;
    logic [15:0] h;
    bit mis;
    is_ld = (opc >= 6'h21 && opc <= 6'h26);
    is_st = (opc >= 6'h35 && opc <= 6'h37);
    sz = (opc == 6'h21 || opc == 6'h22 || opc == 6'h35) ? 4 :
         (opc == 6'h23 || opc == 6'h24 || opc == 6'h36) ? 1 : 2;
    sx = (opc == 6'h22 || opc == 6'h24 || opc == 6'h26);
    ea = ra + {{16{off[15]}}, off};
    ln = ea[1:0];
    mis = (sz == 2 && ln[0]) || (sz == 4 && ln != 2'd0);
    exp_be = (sz == 1) ? (4'b1000 >> ln) : (sz == 2) ? (ln[1] ? 4'b0011 : 4'b1100) : 4'b1111;
    exp_wd = (sz == 1) ? {4{rb[7:0]}} : (sz == 2) ? {2{rb[15:0]}} : rb;
    b = rdata[31 - 8*ln -: 8];
    h = ln[1] ? rdata[15:0] : rdata[31:16];
    exp_ld = (sz == 1) ? {{24{sx & b[7]}}, b} : (sz == 2) ? {{16{sx & h[15]}}, h} : rdata;

    @(negedge clk);
    op_valid = 1'b1;
    op_ra    = ra;
    op_rb    = rb;
    op_insn  = is_st ? {opc, off[15:11], 5'd2, 5'd3, off[10:0]} : {opc, 5'd1, 5'd2, off};
    @(negedge clk);
    op_valid = 1'b0;
    if (!is_ld && !is_st) begin
      check(!mem_req && !misalign && !ld_valid, "R3 ignored opcode",
            {29'd0, mem_req, misalign, ld_valid}, 32'd0);
      @(negedge clk);
      check(!mem_req && !ld_valid, "R3 ignored opcode later", {30'd0, mem_req, ld_valid}, 32'd0);
      return;
    end
    if (mis) begin
      check(misalign && !mem_req, "R8 misaligned flag", {30'd0, misalign, mem_req}, 32'd2);
      @(negedge clk);
      check(!misalign && !mem_req && !ld_valid, "R8 flag one cycle",
            {29'd0, misalign, mem_req, ld_valid}, 32'd0);
      return;
    end
    check(mem_req && !op_ready, "R9 request up", {30'd0, mem_req, op_ready}, 32'd2);
    check(mem_addr == ea, is_st ? "R2 store address" : "R1 load address", mem_addr, ea);
    check(mem_we == is_st, "R5 direction", {31'd0, mem_we}, {31'd0, is_st});
    check(mem_be == exp_be, "R4 byte enables", {28'd0, mem_be}, {28'd0, exp_be});
    if (is_st) check(mem_wdata == exp_wd, "R5 write data", mem_wdata, exp_wd);
    for (int d = 0; d < delay; d++) begin
      op_valid = probe;
      op_insn  = {6'h21, 5'd1, 5'd2, 16'h0000};
      op_ra    = 32'h0000_0100;
      @(negedge clk);
      check(mem_req && mem_addr == ea && !op_ready, "R9 hold while pending", mem_addr, ea);
    end
    op_valid  = 1'b0;
    mem_ack   = 1'b1;
    mem_rdata = rdata;
    @(negedge clk);
    mem_ack   = 1'b0;
    mem_rdata = ~rdata;
    check(!mem_req, "R9 request dropped", {31'd0, mem_req}, 32'd0);
    if (is_ld) begin
      check(ld_valid, "R10 load pulse", {31'd0, ld_valid}, 32'd1);
      check(ld_data == exp_ld, sx ? "R7 sign-extended load" : "R6 unsigned load", ld_data, exp_ld);
    end else begin
      check(!ld_valid, "R10 no pulse on store", {31'd0, ld_valid}, 32'd0);
    end
    @(negedge clk);
    check(!ld_valid && !mem_req, "R10 pulse one cycle and R9 no extra request",
          {30'd0, ld_valid, mem_req}, 32'd0);
  endtask

  initial begin
    logic [5:0]  opcs [10];
    logic [15:0] offs [4];
    opcs = '{6'h21, 6'h22, 6'h23, 6'h24, 6'h25, 6'h26, 6'h35, 6'h36, 6'h37, 6'h15};
    offs = '{16'h0004, 16'hFFF8, 16'h7FF0, 16'h8000};
    repeat (3) @(negedge clk);
    check(!mem_req && !ld_valid && !misalign && op_ready, "R9 reset state",
          {28'd0, mem_req, ld_valid, misalign, op_ready}, 32'd1);
    rst_n = 1'b1;
    for (int o = 0; o < 10; o++)
      for (int f = 0; f < 4; f++)
        for (int lo = 0; lo < 4; lo++)
          for (int p = 0; p < 2; p++)
            run_op(opcs[o], offs[f], 32'h1000_0000 + lo,
                   p ? 32'h1E2D_3C4B : 32'hC3D2_E1F0,
                   p ? 32'h7F01_E655 : 32'h8192_A3B4,
                   (lo + p) % 3, p[0]);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 100000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule